// File: doc/BRIEF.md
# Minute and Day Timekeeper with Event Alarm

This block keeps the current time as two counters: a minute-of-day count and a day count. A one-minute tick input advances them. It also holds an event time, made of its own minute and day fields, and a tone configuration made of an enable and a two-bit tone selection. When the current time reaches the event time while the tone is enabled, the block raises a one-cycle tone request for a separate sound stage.

A command engine drives the block. It can take an atomic snapshot of the current time, so that minutes and days always come from the same instant. It can load a new current time. It can write the event time, and it can write the tone configuration.

Loading the current time does not leave the alarm at a fixed absolute time. The stored event time moves by the same amount as the current time, so the time remaining until the alarm stays the same after the load.

Top module: `tk_timekeeper`

## Requirements
- R1: After reset, all of these are zero: the current minute and day, the event minute and day, the snapshot minute and day, the tone enable, the tone selection and the tone request.
- R2: A tick without a load advances the minute count by one on the next clock edge. A tick at minute 1439 sets the minute to 0 and adds one to the day.
- R3: The day count wraps from 4095 to 0 when the minute count rolls over.
- R4: A load sets the current minute and day to the load inputs on the next edge. A load wins over a tick in the same cycle, and that tick is dropped.
- R5: A load without an event write in the same cycle moves the event time. Let the span be 1440×4096 minutes, and measure each time as day×1440 + minute. The value (event − current) modulo the span is the same after the load as before it. The event minute stays in 0..1439, with a borrow from or a carry into the event day.
- R6: An event write stores the given minute and day on the next edge. In the same cycle it wins over the load adjustment of R5.
- R7: A snapshot request copies the current minute and day, as held before that edge, into the snapshot outputs. A tick or load in the same cycle does not change what is captured.
- R8: A tone write sets the tone enable only when the 4-bit enable nybble equals exactly 4'h1; any other value clears it. The same write sets the tone selection from the 2-bit selection input.
- R9: The tone request goes high for one cycle, one clock after both of these become true together: the current time equals the event time (minutes and days), and the tone is enabled. This includes the case where the enable is written while the two times are already equal. There is no request while the tone is disabled.
- R10: While the equality and the enable stay true, the tone request does not repeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| min_tick | input | 1 | One-minute advance strobe |
| time_load | input | 1 | Load the current time from load_min/load_day |
| load_min | input | 12 | Minute of day to load (0..1439) |
| load_day | input | 12 | Day to load |
| time_snap | input | 1 | Capture the current time into the snapshot outputs |
| snap_min | output | 12 | Captured minute |
| snap_day | output | 12 | Captured day |
| cur_min | output | 12 | Current minute of day |
| cur_day | output | 12 | Current day |
| evt_wr | input | 1 | Write the event time |
| evt_min_in | input | 12 | Event minute to write (0..1439) |
| evt_day_in | input | 12 | Event day to write |
| evt_min | output | 12 | Stored event minute |
| evt_day | output | 12 | Stored event day |
| tone_wr | input | 1 | Write the tone configuration |
| tone_en_nyb | input | 4 | Enable nybble; only 4'h1 enables |
| tone_sel_in | input | 2 | Tone selection to store |
| tone_on | output | 1 | Tone enabled |
| tone_sel | output | 2 | Stored tone selection |
| tone_req | output | 1 | One-cycle alarm pulse |

## Verification
The hardest cases to reach are the borrow and carry paths of the event shift. They occur only when a load moves the current time across the midnight boundary relative to the stored event, sometimes together with day wrap at 4095. The stimulus sweeps a grid of starting times, event times and load targets, including minute 0, minute 1439, day 0 and day 4095. For each case the expected event time comes from flat minute arithmetic modulo the full span, not from separate field arithmetic. The alarm edge is reached in two ways: by ticking the current time into the event time, and by enabling the tone while the two times are already equal.

// File: rtl/tk_pkg.sv
package tk_pkg;
    localparam int NYB_W       = 4;
    localparam int TIME_NYB    = 3;
    localparam int TIME_W      = NYB_W * TIME_NYB;
    localparam int MIN_PER_DAY = 1440;
    localparam int SEL_W       = 2;
    localparam int EN_CODE     = 1;

    typedef logic [TIME_W-1:0] tfield_t;

    typedef struct packed {
        tfield_t day;
        tfield_t min;
    } tstamp_t;

    // Distance from c forward to e in minutes, modulo the full span.
    function automatic logic [31:0] tk_dist(tstamp_t e, tstamp_t c);
        logic [31:0] ae, ac, span;
        span = 32'(MIN_PER_DAY) << TIME_W;
        ae   = 32'(e.day) * 32'(MIN_PER_DAY) + 32'(e.min);
        ac   = 32'(c.day) * 32'(MIN_PER_DAY) + 32'(c.min);
        if (ae >= ac) return ae - ac;
        return ae + span - ac;
    endfunction
endpackage

// File: rtl/tk_clock.sv
module tk_clock
    import tk_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    input  logic    load,
    input  tstamp_t load_val,
    input  logic    snap,
    output tstamp_t cur,
    output tstamp_t snap_val
);
    localparam tfield_t LAST_MIN = TIME_W'(MIN_PER_DAY - 1);
    localparam tfield_t ONE      = TIME_W'(1);

    typedef struct packed {
        tstamp_t cur;
        tstamp_t snap;
    } clk_st_t;

    clk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (snap) st_d.snap = st_q.cur;
        if (load) begin
            st_d.cur = load_val;
        end else if (tick) begin
            if (st_q.cur.min >= LAST_MIN) begin
                st_d.cur.min = '0;
                st_d.cur.day = st_q.cur.day + ONE;
            end else begin
                st_d.cur.min = st_q.cur.min + ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur      = st_q.cur;
    assign snap_val = st_q.snap;

    assert_min_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cur.min < LAST_MIN) |=> (cur.min == $past(cur.min) + ONE) && $stable(cur.day));
    assert_min_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cur.min == LAST_MIN) |=> (cur.min == '0) && (cur.day == $past(cur.day) + ONE));
    assert_day_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cur.min == LAST_MIN && cur.day == '1) |=> (cur.day == '0));
    assert_load_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cur == $past(load_val)));
    assert_snap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (snap_val == $past(cur)));
endmodule

// File: rtl/tk_event.sv
module tk_event
    import tk_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  tstamp_t cur,
    input  logic    load,
    input  tstamp_t load_val,
    input  logic    wr,
    input  tstamp_t wr_val,
    output tstamp_t evt
);
    localparam int EXT_W = TIME_W + 3;
    typedef logic signed [EXT_W-1:0] ext_t;
    localparam ext_t SPAN = ext_t'(MIN_PER_DAY);
    localparam ext_t ZERO = ext_t'(0);

    typedef struct packed {
        tstamp_t evt;
    } evt_st_t;

    evt_st_t st_d, st_q;
    ext_t    dmin, emin;
    tfield_t dadj;

    always_comb begin
        st_d = st_q;
        dmin = $signed({3'b000, load_val.min}) - $signed({3'b000, cur.min});
        emin = $signed({3'b000, st_q.evt.min}) + dmin;
        dadj = '0;
        if (emin < ZERO) begin
            emin = emin + SPAN;
            dadj = '1;
        end else if (emin >= SPAN) begin
            emin = emin - SPAN;
            dadj = TIME_W'(1);
        end
        if (wr) begin
            st_d.evt = wr_val;
        end else if (load) begin
            st_d.evt.min = emin[TIME_W-1:0];
            st_d.evt.day = st_q.evt.day + load_val.day - cur.day + dadj;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt = st_q.evt;

    assert_gap_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !wr) |=> (tk_dist(evt, cur) == $past(tk_dist(evt, cur))));
    assert_evt_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (evt == $past(wr_val)));
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !load) |=> $stable(evt));
endmodule

// File: rtl/tk_tone.sv
module tk_tone
    import tk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  tstamp_t          cur,
    input  tstamp_t          evt,
    input  logic             cfg_wr,
    input  logic [NYB_W-1:0] en_nyb,
    input  logic [SEL_W-1:0] sel_in,
    output logic             tone_on,
    output logic [SEL_W-1:0] tone_sel,
    output logic             tone_req
);
    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
        logic             hit;
        logic             req;
    } tone_st_t;

    tone_st_t st_d, st_q;
    logic     hit_now;

    always_comb begin
        st_d    = st_q;
        hit_now = (cur == evt) && st_q.en;
        if (cfg_wr) begin
            st_d.en  = (en_nyb == NYB_W'(EN_CODE));
            st_d.sel = sel_in;
        end
        st_d.hit = hit_now;
        st_d.req = hit_now && !st_q.hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tone_on  = st_q.en;
    assign tone_sel = st_q.sel;
    assign tone_req = st_q.req;

    assert_en_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (tone_on == ($past(en_nyb) == NYB_W'(EN_CODE))));
    assert_req_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tone_req |-> $past(cur == evt && tone_on));
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tone_req |=> !tone_req);
endmodule

// File: rtl/tk_timekeeper.sv
module tk_timekeeper
    import tk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              min_tick,
    input  logic              time_load,
    input  logic [TIME_W-1:0] load_min,
    input  logic [TIME_W-1:0] load_day,
    input  logic              time_snap,
    output logic [TIME_W-1:0] snap_min,
    output logic [TIME_W-1:0] snap_day,
    output logic [TIME_W-1:0] cur_min,
    output logic [TIME_W-1:0] cur_day,
    input  logic              evt_wr,
    input  logic [TIME_W-1:0] evt_min_in,
    input  logic [TIME_W-1:0] evt_day_in,
    output logic [TIME_W-1:0] evt_min,
    output logic [TIME_W-1:0] evt_day,
    input  logic              tone_wr,
    input  logic [NYB_W-1:0]  tone_en_nyb,
    input  logic [SEL_W-1:0]  tone_sel_in,
    output logic              tone_on,
    output logic [SEL_W-1:0]  tone_sel,
    output logic              tone_req
);
    tstamp_t load_val, wr_val, cur, snap_val, evt;

    assign load_val = '{day: load_day, min: load_min};
    assign wr_val   = '{day: evt_day_in, min: evt_min_in};

    tk_clock i_clock (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (min_tick),
        .load     (time_load),
        .load_val (load_val),
        .snap     (time_snap),
        .cur      (cur),
        .snap_val (snap_val)
    );

    tk_event i_event (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur      (cur),
        .load     (time_load),
        .load_val (load_val),
        .wr       (evt_wr),
        .wr_val   (wr_val),
        .evt      (evt)
    );

    tk_tone i_tone (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur      (cur),
        .evt      (evt),
        .cfg_wr   (tone_wr),
        .en_nyb   (tone_en_nyb),
        .sel_in   (tone_sel_in),
        .tone_on  (tone_on),
        .tone_sel (tone_sel),
        .tone_req (tone_req)
    );

    assign cur_min  = cur.min;
    assign cur_day  = cur.day;
    assign snap_min = snap_val.min;
    assign snap_day = snap_val.day;
    assign evt_min  = evt.min;
    assign evt_day  = evt.day;
endmodule

// File: tb/test_tk_timekeeper.sv
module test_tk_timekeeper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        min_tick = 1'b0, time_load = 1'b0, time_snap = 1'b0;
    logic        evt_wr = 1'b0, tone_wr = 1'b0;
    logic [11:0] load_min = '0, load_day = '0, evt_min_in = '0, evt_day_in = '0;
    logic [3:0]  tone_en_nyb = '0;
    logic [1:0]  tone_sel_in = '0;
    logic [11:0] snap_min, snap_day, cur_min, cur_day, evt_min, evt_day;
    logic        tone_on, tone_req;
    logic [1:0]  tone_sel;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;
    int m_min, m_day;

    always #4 clk = ~clk;

    tk_timekeeper i_tk_timekeeper (
        .clk(clk), .rst_n(rst_n), .min_tick(min_tick), .time_load(time_load),
        .load_min(load_min), .load_day(load_day), .time_snap(time_snap),
        .snap_min(snap_min), .snap_day(snap_day), .cur_min(cur_min), .cur_day(cur_day),
        .evt_wr(evt_wr), .evt_min_in(evt_min_in), .evt_day_in(evt_day_in),
        .evt_min(evt_min), .evt_day(evt_day), .tone_wr(tone_wr),
        .tone_en_nyb(tone_en_nyb), .tone_sel_in(tone_sel_in), .tone_on(tone_on),
        .tone_sel(tone_sel), .tone_req(tone_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_load(input int m, input int d);
        time_load = 1'b1; load_min = 12'(m); load_day = 12'(d);
        cyc();
        time_load = 1'b0;
    endtask

    task automatic do_evt(input int m, input int d);
        evt_wr = 1'b1; evt_min_in = 12'(m); evt_day_in = 12'(d);
        cyc();
        evt_wr = 1'b0;
    endtask

    task automatic do_tick();
        min_tick = 1'b1;
        cyc();
        min_tick = 1'b0;
    endtask

    task automatic do_tone(input int en, input int sel);
        tone_wr = 1'b1; tone_en_nyb = 4'(en); tone_sel_in = 2'(sel);
        cyc();
        tone_wr = 1'b0;
    endtask

    function automatic longint shifted(input int em, input int ed, input int cm,
                                       input int cd, input int lm, input int ld);
        longint span, e, c, l;
        span = 64'd1440 * 64'd4096;
        e = longint'(ed) * 1440 + em;
        c = longint'(cd) * 1440 + cm;
        l = longint'(ld) * 1440 + lm;
        return (l + ((e - c + span) % span)) % span;
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int mins[4] = '{0, 1, 700, 1439};
        int days[3] = '{0, 5, 4095};
        longint nv;
        cyc(); cyc();
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 cur_min", int'(cur_min), 0);
        chk("R1 cur_day", int'(cur_day), 0);
        chk("R1 evt_min", int'(evt_min), 0);
        chk("R1 evt_day", int'(evt_day), 0);
        chk("R1 snap", int'({snap_day, snap_min}), 0);
        chk("R1 tone", int'({tone_on, tone_sel, tone_req}), 0);

        // R2 sweep of two full days of ticks
        m_min = 0; m_day = 0;
        for (int i = 0; i < 2 * 1440 + 5; i++) begin
            do_tick();
            m_min = m_min + 1;
            if (m_min == 1440) begin m_min = 0; m_day = m_day + 1; end
            chk("R2 min", int'(cur_min), m_min);
            chk("R2 day", int'(cur_day), m_day);
        end

        // R3 day wrap
        do_load(1438, 4095);
        do_tick();
        chk("R3 pre min", int'(cur_min), 1439);
        chk("R3 pre day", int'(cur_day), 4095);
        do_tick();
        chk("R3 wrap min", int'(cur_min), 0);
        chk("R3 wrap day", int'(cur_day), 0);

        // R4 load wins over tick
        min_tick = 1'b1;
        do_load(250, 33);
        min_tick = 1'b0;
        chk("R4 min", int'(cur_min), 250);
        chk("R4 day", int'(cur_day), 33);

        // R7 snapshot with concurrent tick, then concurrent load
        do_load(100, 7);
        time_snap = 1'b1; min_tick = 1'b1;
        cyc();
        time_snap = 1'b0; min_tick = 1'b0;
        chk("R7 snap min", int'(snap_min), 100);
        chk("R7 snap day", int'(snap_day), 7);
        chk("R7 cur min", int'(cur_min), 101);
        time_snap = 1'b1;
        do_load(300, 9);
        time_snap = 1'b0;
        chk("R7 snap min load", int'(snap_min), 101);
        chk("R7 snap day load", int'(snap_day), 7);
        chk("R7 cur day load", int'(cur_day), 9);

        // R5 / R6 grid of event shifts
        foreach (mins[a]) foreach (days[b]) foreach (mins[c]) foreach (days[d])
        foreach (mins[e]) foreach (days[f]) begin
            do_load(mins[a], days[b]);
            do_evt(mins[c], days[d]);
            chk("R6 evt min", int'(evt_min), mins[c]);
            chk("R6 evt day", int'(evt_day), days[d]);
            do_load(mins[e], days[f]);
            nv = shifted(mins[c], days[d], mins[a], days[b], mins[e], days[f]);
            chk("R5 evt min", int'(evt_min), int'(nv % 1440));
            chk("R5 evt day", int'(evt_day), int'(nv / 1440));
        end

        // R6 event write wins over load adjustment
        do_load(10, 10);
        do_evt(20, 10);
        evt_wr = 1'b1; evt_min_in = 12'd555; evt_day_in = 12'd66;
        do_load(900, 2);
        evt_wr = 1'b0;
        chk("R6 prio min", int'(evt_min), 555);
        chk("R6 prio day", int'(evt_day), 66);

        // R8 sweep of enable nybble and selection
        for (int en = 0; en < 16; en++) begin
            for (int s = 0; s < 4; s++) begin
                do_tone(en, s);
                chk("R8 enable", int'(tone_on), (en == 1) ? 1 : 0);
                chk("R8 sel", int'(tone_sel), s);
            end
        end

        // R9 / R10 alarm reached by ticking
        do_tone(0, 0);
        do_load(10, 5);
        do_evt(12, 5);
        do_tone(1, 2);
        chk("R9 idle", int'(tone_req), 0);
        do_tick();
        do_tick();
        chk("R9 same edge", int'(tone_req), 0);
        cyc();
        chk("R9 pulse", int'(tone_req), 1);
        cyc();
        chk("R10 drop", int'(tone_req), 0);
        for (int i = 0; i < 4; i++) begin
            cyc();
            chk("R10 no repeat", int'(tone_req), 0);
        end

        // R9 disabled: no pulse; then enable while equal
        do_tone(3, 1);
        do_load(40, 8);
        do_evt(41, 8);
        do_tick();
        for (int i = 0; i < 3; i++) begin
            cyc();
            chk("R9 disabled", int'(tone_req), 0);
        end
        do_tone(1, 1);
        chk("R9 enable edge", int'(tone_req), 0);
        cyc();
        chk("R9 enable pulse", int'(tone_req), 1);
        cyc();
        chk("R10 enable drop", int'(tone_req), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule